// File: doc/BRIEF.md
# Host Controller Interrupt Unit

This block collects one-cycle event pulses from the rest of a host controller and latches each into a sticky pending bit. It decides from a software-programmed enable mask whether a single interrupt line to the host is raised. The sources are scheduling overrun, done-head write-back, start of frame, resume detected, unrecoverable error, frame number overflow, root hub status change and ownership change. Software reaches the pending bits and the enable mask through a small register port with a combinational read path and a single-cycle write strobe.

The enable mask has no direct write address. Bits are turned on through a set address and turned off through a clear address, and both addresses read back the current mask. The top bit of the mask is a master enable that gates every source at once. Pending bits are cleared by writing 1 to them at the status address.

Top module: `hc_irq_unit`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, reads at all addresses return 0, and `irqOut` is 0.
- R2: A 1 on `evtIn[i]` at a clock edge sets pending bit i for i = 0..6 and pending bit 30 for i = 7. The bit is visible on the next read of the status address (`regAddr` = 0).
- R3: A write at the status address clears every pending bit whose data bit is 1 and leaves pending bits whose data bit is 0 unchanged.
- R4: A write at the set address (`regAddr` = 1) sets every implemented enable bit whose data bit is 1, and leaves the others unchanged.
- R5: A write at the clear address (`regAddr` = 2) clears every enable bit whose data bit is 1, and leaves the others unchanged.
- R6: Reads at the set address and at the clear address both return the current enable mask.
- R7: `irqOut` is 1 exactly when enable bit 31 is 1 and some pending bit is 1 with its enable bit also 1. It follows register state in the cycle after the edge that changed that state.
- R8: If an event pulse and a clearing status write hit the same pending bit at the same edge, the bit ends up set.
- R9: Only bits 0..6 and 30 of the pending register and bits 0..6, 30 and 31 of the mask are implemented. Other positions read 0 and ignore writes. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 8 | One-cycle event pulses, index order as in R2 |
| regAddr | input | 2 | Register select: 0 status, 1 enable set, 2 enable clear, 3 unused |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
Because reads are combinational, a wrong pending or mask bit shows at `rdData` on the first read after the edge that corrupted it. Through `irqOut` it shows in the same cycle when that bit takes part in the gating. A set/clear path that touches the wrong bits shows up on a readback at the other alias address. A lost race between an event and a clear shows as a missing status bit one cycle later. Writes of zeros, writes to unimplemented bits and writes to the unused address are each followed by a readback, so that any side effect appears before the next stimulus.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_SRC  = 8;
  localparam int ADDR_W   = 2;
  localparam int HIGH_POS = 30;
  localparam int MASTER   = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_SET    = 2'd1,
    ADDR_CLR    = 2'd2,
    ADDR_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic clrSt;
    logic rdStat;
    logic rdMask;
  } strobes_t;

  function automatic int srcPos(input int idx);
    return (idx < NUM_SRC - 1) ? idx : HIGH_POS;
  endfunction

  function automatic logic [DATA_W-1:0] srcMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[srcPos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SRC_MASK = srcMask();
  localparam logic [DATA_W-1:0] EN_MASK  = SRC_MASK | (DATA_W'(1) << MASTER);
endpackage

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl
  import hc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  output strobes_t          strobes
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strobes = '0;
    strobes.setEn  = wrEn && (sel == ADDR_SET);
    strobes.clrEn  = wrEn && (sel == ADDR_CLR);
    strobes.clrSt  = wrEn && (sel == ADDR_STATUS);
    strobes.rdStat = (sel == ADDR_STATUS);
    strobes.rdMask = (sel == ADDR_SET) || (sel == ADDR_CLR);
  end

  // R9: at most one write strobe per cycle, none for the unused address
  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setEn, strobes.clrEn, strobes.clrSt}));
endmodule

// File: rtl/hc_irq_datapath.sv
module hc_irq_datapath
  import hc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [DATA_W-1:0] evtBits;
  logic [DATA_W-1:0] statusQ, statusNext;
  logic [DATA_W-1:0] maskQ, maskNext;
  logic [DATA_W-1:0] clrBits;

  always_comb begin
    evtBits = '0;
    for (int i = 0; i < NUM_SRC; i++) evtBits[srcPos(i)] = evtIn[i];
  end

  assign clrBits    = strobes.clrSt ? wrData : '0;
  assign statusNext = ((statusQ & ~clrBits) | evtBits) & SRC_MASK;

  always_comb begin
    maskNext = maskQ;
    if (strobes.setEn)      maskNext = maskQ | (wrData & EN_MASK);
    else if (strobes.clrEn) maskNext = maskQ & ~wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
    end
  end

  assign rdData = strobes.rdStat ? statusQ : (strobes.rdMask ? maskQ : '0);
  assign irqOut = maskQ[MASTER] & (|(statusQ & maskQ & SRC_MASK));

  // R2 / R8: every pulsed event is pending one cycle later, whatever the write did
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((statusQ & $past(evtBits)) == $past(evtBits)));

  // R3: bits cleared by a status write without a racing event are gone
  assert_status_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrSt |=> ((statusQ & $past(wrData & ~evtBits)) == '0));

  // R4: set writes turn on all requested implemented bits
  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setEn |=> ((maskQ & $past(wrData & EN_MASK)) == $past(wrData & EN_MASK)));

  // R5: clear writes turn off all requested bits
  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrEn |=> ((maskQ & $past(wrData)) == '0));

  // R7: with the master enable off the line stays low
  assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[MASTER] |-> !irqOut);
endmodule

// File: rtl/hc_irq_unit.sv
module hc_irq_unit
  import hc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  strobes_t strobes;

  hc_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  hc_irq_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .evtIn   (evtIn),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/hc_irq_unit_tb.sv
module hc_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 82;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  evtIn = '0;
  logic [1:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_irq_unit u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // fields: req[4] wr[1] addr[2] wdata[32] evt[8] chkAddr[2] expRd[32] expIrq[1]
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 1'b0, 2'd0, 32'h0000_0000, 8'h01, 2'd0, 32'h0000_0001, 1'b0}, // R2 bit0
    {4'd4, 1'b1, 2'd1, 32'h0000_0001, 8'h00, 2'd1, 32'h0000_0001, 1'b0}, // R4, R7 master off
    {4'd7, 1'b1, 2'd1, 32'h8000_0000, 8'h00, 2'd1, 32'h8000_0001, 1'b1}, // R7 raise
    {4'd2, 1'b0, 2'd0, 32'h0000_0000, 8'h80, 2'd0, 32'h4000_0001, 1'b1}, // R2 input7 -> bit30
    {4'd3, 1'b1, 2'd0, 32'h0000_0001, 8'h00, 2'd0, 32'h4000_0000, 1'b0}, // R3 clear bit0
    {4'd6, 1'b1, 2'd1, 32'h4000_0000, 8'h00, 2'd2, 32'hC000_0001, 1'b1}, // R6 clear alias reads mask
    {4'd5, 1'b1, 2'd2, 32'h4000_0000, 8'h00, 2'd1, 32'h8000_0001, 1'b0}, // R5 clear bit30
    {4'd9, 1'b1, 2'd1, 32'hFFFF_FFFF, 8'h00, 2'd1, 32'hC000_007F, 1'b1}, // R9 unused enable bits
    {4'd8, 1'b1, 2'd0, 32'hFFFF_FFFF, 8'h04, 2'd0, 32'h0000_0004, 1'b1}, // R8 race keeps bit2
    {4'd5, 1'b1, 2'd2, 32'h0000_0000, 8'h00, 2'd2, 32'hC000_007F, 1'b1}, // R5 zero write
    {4'd3, 1'b1, 2'd0, 32'h0000_0000, 8'h00, 2'd0, 32'h0000_0004, 1'b1}, // R3 zero write
    {4'd9, 1'b1, 2'd3, 32'hFFFF_FFFF, 8'h00, 2'd3, 32'h0000_0000, 1'b1}, // R9 unused address
    {4'd9, 1'b0, 2'd0, 32'h0000_0000, 8'h00, 2'd1, 32'hC000_007F, 1'b1}, // R9 mask untouched
    {4'd7, 1'b1, 2'd2, 32'h8000_0000, 8'h00, 2'd0, 32'h0000_0004, 1'b0}, // R7 master off
    {4'd2, 1'b0, 2'd0, 32'h0000_0000, 8'h7F, 2'd0, 32'h0000_007F, 1'b0}  // R2 all low sources
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got %h expected %h", req, got, exp);
    end
  endtask

  task automatic checkResetState();
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a);
      #1;
      check(1, rdData, 32'h0); // R1
    end
    check(1, {31'b0, irqOut}, 32'h0); // R1
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    @(negedge clk);
    checkResetState();

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      wrEn    = v[77];
      regAddr = v[76:75];
      wrData  = v[74:43];
      evtIn   = v[42:35];
      @(negedge clk);
      wrEn    = 1'b0;
      evtIn   = '0;
      wrData  = '0;
      regAddr = v[34:33];
      #1;
      check(int'(v[81:78]), rdData, v[32:1]);
      check(int'(v[81:78]), {31'b0, irqOut}, {31'b0, v[0]});
    end

    // R1: reset from a busy state returns everything to zero
    rstN = 1'b0;
    @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    @(negedge clk);
    checkResetState();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule